// File: doc/BRIEF.md
# Mailbox Doorbell Command Interface

This block is the device-side register window that a host uses to hand fixed-size commands to a local engine and to collect the results. The host fills a 13-byte mailbox with byte writes, then rings the inbound doorbell. The block copies the mailbox into a shadow buffer and reports itself busy. It then offers the shadow copy on a valid/ready command port. Once the engine takes the command, busy drops and the host may post again.

The engine returns a completion on a second valid/ready port. A completion is an 8-bit slot identifier and a 16-bit status word. The block stores both and raises a status-available flag in the outbound doorbell. The interrupt line follows that flag when interrupts are enabled. The host retires a completion in two writes. First it clears the outbound flag. Then it strobes the status-acknowledge bit in the inbound doorbell. Only after both writes will the block accept the next completion.

A parameter selects the inverted-readiness variant. In that variant the doorbell flag reads as "mailbox empty" rather than "mailbox full". The interrupt control bit in that variant is an active-high disable.

Top module: `cmd_doorbell_if`

## Requirements
- R1: After reset there is no command on offer, no status available and the interrupt is low. The doorbell flag (address 0x10, bit 0) reads 0 in the normal variant and 1 in the inverted variant. Interrupts start disabled in both variants.
- R2: Mailbox byte i (0 to 12) is written and read at address i. Writing a 1 to bit 0 of address 0x10 while idle posts the command. From the next cycle cmd_valid is high and cmd_data[8i+7:8i] equals mailbox byte i as it stood when the command was posted.
- R3: Bit 0 of address 0x10 reads 1 while a command is in flight in the normal variant. In the inverted variant it reads 1 while the mailbox is free to take a command.
- R4: While a command is in flight, a further post is ignored and mailbox writes leave cmd_data unchanged. Those writes still update the mailbox bytes read back at addresses 0 to 12.
- R5: cmd_valid stays high until a cycle with cmd_ready high. It is low in the cycle after that handshake.
- R6: A completion is accepted in a cycle with comp_valid and comp_ready both high. From the next cycle, bit 0 of address 0x11 reads 1, address 0x13 returns the slot in bits 7:0 and address 0x14 returns the 16-bit status.
- R7: Bit 0 of address 0x11 is write-one-to-clear. A write with bit 0 at zero leaves it set.
- R8: comp_ready is low while status is available or an acknowledge is pending. Writing 1 to bit 1 of address 0x10 ends the pending acknowledge only when status-available is already clear. Written while it is set, that bit is ignored.
- R9: Address 0x12 controls the interrupt. In the normal variant any nonzero byte enables it and zero disables it. In the inverted variant bit 0 is an active-high disable. irq is high exactly when status is available and the interrupt is enabled.
- R10: A write to address 0x10 with bit 0 at zero does not post a command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hst_we | input | 1 | Host register write strobe |
| hst_addr | input | 5 | Host register address |
| hst_wdata | input | 8 | Host write byte |
| hst_rdata | output | 16 | Read data for hst_addr; combinational, no read side effects |
| cmd_valid | output | 1 | Command on offer |
| cmd_ready | input | 1 | Engine takes the command |
| cmd_data | output | 104 | Shadowed command bytes, byte 0 in the low bits |
| comp_valid | input | 1 | Engine offers a completion |
| comp_ready | output | 1 | Block can store a completion |
| comp_slot | input | 8 | Completion slot identifier |
| comp_status | input | 16 | Completion status word |
| irq | output | 1 | Interrupt request |

## Verification
The bench drives a normal-variant instance and an inverted-variant instance from the same host writes, and compares both against a behavioural model on every cycle. It overwrites the mailbox and rings the doorbell again while a command is in flight. A design without the shadow copy, or one that accepts the second post, would change cmd_data under the engine. It strobes the acknowledge bit before clearing status-available. A design that ignores the ordering would accept a new completion too early. It also writes all-zero doorbell bytes and a zero interrupt byte. A design that treats these as plain stores would drop the flag, post a spurious command, or give the two variants the same interrupt behaviour.

// File: rtl/cmddb_pkg.sv
package cmddb_pkg;
  localparam int ADDR_W = 5;
  localparam int RD_W   = 16;

  localparam logic [ADDR_W-1:0] A_INBOUND  = 5'h10;
  localparam logic [ADDR_W-1:0] A_OUTBOUND = 5'h11;
  localparam logic [ADDR_W-1:0] A_INTCTL   = 5'h12;
  localparam logic [ADDR_W-1:0] A_SLOT     = 5'h13;
  localparam logic [ADDR_W-1:0] A_STATUS   = 5'h14;

  localparam int BIT_POST  = 0;
  localparam int BIT_SACK  = 1;
  localparam int BIT_AVAIL = 0;

  // Flag shown to the host at the inbound doorbell.
  function automatic logic ready_flag(input logic busy, input logic invert);
    return invert ? ~busy : busy;
  endfunction

  // Stored interrupt control bit -> effective enable.
  function automatic logic irq_enabled(input logic ctl, input logic invert);
    return invert ? ~ctl : ctl;
  endfunction

  // Host byte -> stored interrupt control bit.
  function automatic logic ctl_from_byte(input logic [7:0] wb, input logic invert);
    return invert ? wb[0] : (|wb);
  endfunction

  // Reset value of the control bit: interrupts disabled.
  function automatic logic ctl_reset(input logic invert);
    return invert;
  endfunction
endpackage

// File: rtl/cdb_mailbox.sv
module cdb_mailbox
  import cmddb_pkg::*;
#(
  parameter int NBYTES = 13
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [ADDR_W-1:0]     wr_addr,
  input  logic [7:0]            wr_byte,
  input  logic                  post_req,
  input  logic                  cmd_ready,
  output logic [NBYTES*8-1:0]   buf_flat,
  output logic                  busy,
  output logic                  cmd_valid,
  output logic [NBYTES*8-1:0]   cmd_data
);
  localparam int DATA_W = NBYTES * 8;

  logic              busy_q;
  logic [DATA_W-1:0] shadow_q;
  logic              post_accept;
  logic              cmd_take;

  for (genvar gi = 0; gi < NBYTES; gi++) begin : g_byte
    logic [7:0] byte_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        byte_q <= '0;
      else if (wr_en && (wr_addr == ADDR_W'(gi)))
        byte_q <= wr_byte;
    end
    assign buf_flat[gi*8 +: 8] = byte_q;
  end

  assign post_accept = post_req && !busy_q;
  assign cmd_take    = busy_q && cmd_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q   <= 1'b0;
      shadow_q <= '0;
    end else begin
      if (post_accept) begin
        busy_q   <= 1'b1;
        shadow_q <= buf_flat;
      end else if (cmd_take) begin
        busy_q <= 1'b0;
      end
    end
  end

  assign busy      = busy_q;
  assign cmd_valid = busy_q;
  assign cmd_data  = shadow_q;

  // R2: an accepted post raises the offer in the next cycle
  p_post_offers_r2: assert property (@(posedge clk) disable iff (!rst_n)
    post_req && !cmd_valid |=> cmd_valid);

  // R4: a command in flight is not altered by host activity
  p_shadow_frozen_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !cmd_ready |=> $stable(cmd_data));

  // R5: offer held until taken, dropped after the handshake
  p_hold_offer_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !cmd_ready |=> cmd_valid);
  p_drop_after_take_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_ready |=> !cmd_valid);
endmodule

// File: rtl/cdb_completion.sv
module cdb_completion
  import cmddb_pkg::*;
#(
  parameter int SLOT_W = 8,
  parameter int STAT_W = 16,
  parameter bit INVERT = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              comp_valid,
  input  logic [SLOT_W-1:0] comp_slot,
  input  logic [STAT_W-1:0] comp_status,
  input  logic              clr_req,
  input  logic              sack_req,
  input  logic              ctl_we,
  input  logic [7:0]        ctl_byte,
  output logic              comp_ready,
  output logic              avail,
  output logic [SLOT_W-1:0] slot_q,
  output logic [STAT_W-1:0] stat_q,
  output logic              ctl_q,
  output logic              irq
);
  logic avail_q;
  logic ackpend_q;
  logic accept;

  assign comp_ready = !avail_q && !ackpend_q;
  assign accept     = comp_valid && comp_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      avail_q   <= 1'b0;
      ackpend_q <= 1'b0;
      slot_q    <= '0;
      stat_q    <= '0;
      ctl_q     <= ctl_reset(INVERT);
    end else begin
      if (accept) begin
        avail_q   <= 1'b1;
        ackpend_q <= 1'b1;
        slot_q    <= comp_slot;
        stat_q    <= comp_status;
      end else begin
        if (clr_req)
          avail_q <= 1'b0;
        if (sack_req && !avail_q)
          ackpend_q <= 1'b0;
      end
      if (ctl_we)
        ctl_q <= ctl_from_byte(ctl_byte, INVERT);
    end
  end

  assign avail = avail_q;
  assign irq   = avail_q && irq_enabled(ctl_q, INVERT);

  // R6: status-available only rises after an offered completion
  p_avail_source_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(avail) |-> $past(comp_valid));

  // R6: stored completion is held while no new one can enter
  p_hold_record_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !comp_ready |=> $stable(slot_q) && $stable(stat_q));

  // R8: acknowledge before clearing does not rearm the port
  p_early_sack_r8: assert property (@(posedge clk) disable iff (!rst_n)
    sack_req && avail && !clr_req |=> !comp_ready);

  // R9: no interrupt without available status
  p_irq_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !avail |-> !irq);
endmodule

// File: rtl/cmd_doorbell_if.sv
module cmd_doorbell_if
  import cmddb_pkg::*;
#(
  parameter int MBOX_BYTES   = 13,
  parameter int SLOT_W       = 8,
  parameter int STAT_W       = 16,
  parameter bit INVERT_READY = 1'b0
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    hst_we,
  input  logic [ADDR_W-1:0]       hst_addr,
  input  logic [7:0]              hst_wdata,
  output logic [RD_W-1:0]         hst_rdata,
  output logic                    cmd_valid,
  input  logic                    cmd_ready,
  output logic [MBOX_BYTES*8-1:0] cmd_data,
  input  logic                    comp_valid,
  output logic                    comp_ready,
  input  logic [SLOT_W-1:0]       comp_slot,
  input  logic [STAT_W-1:0]       comp_status,
  output logic                    irq
);
  localparam int DATA_W = MBOX_BYTES * 8;

  logic              hit_mbox;
  logic              hit_in;
  logic              hit_out;
  logic              hit_ctl;
  logic              post_req;
  logic              sack_req;
  logic              clr_req;
  logic              ctl_we;
  logic [DATA_W-1:0] buf_flat;
  logic              busy;
  logic              avail;
  logic [SLOT_W-1:0] slot_q;
  logic [STAT_W-1:0] stat_q;
  logic              ctl_q;

  assign hit_mbox = int'(hst_addr) < MBOX_BYTES;
  assign hit_in   = hst_addr == A_INBOUND;
  assign hit_out  = hst_addr == A_OUTBOUND;
  assign hit_ctl  = hst_addr == A_INTCTL;

  assign post_req = hst_we && hit_in  && hst_wdata[BIT_POST];
  assign sack_req = hst_we && hit_in  && hst_wdata[BIT_SACK];
  assign clr_req  = hst_we && hit_out && hst_wdata[BIT_AVAIL];
  assign ctl_we   = hst_we && hit_ctl;

  cdb_mailbox #(.NBYTES(MBOX_BYTES)) u_mbox (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (hst_we && hit_mbox),
    .wr_addr   (hst_addr),
    .wr_byte   (hst_wdata),
    .post_req  (post_req),
    .cmd_ready (cmd_ready),
    .buf_flat  (buf_flat),
    .busy      (busy),
    .cmd_valid (cmd_valid),
    .cmd_data  (cmd_data)
  );

  cdb_completion #(.SLOT_W(SLOT_W), .STAT_W(STAT_W), .INVERT(INVERT_READY)) u_comp (
    .clk         (clk),
    .rst_n       (rst_n),
    .comp_valid  (comp_valid),
    .comp_slot   (comp_slot),
    .comp_status (comp_status),
    .clr_req     (clr_req),
    .sack_req    (sack_req),
    .ctl_we      (ctl_we),
    .ctl_byte    (hst_wdata),
    .comp_ready  (comp_ready),
    .avail       (avail),
    .slot_q      (slot_q),
    .stat_q      (stat_q),
    .ctl_q       (ctl_q),
    .irq         (irq)
  );

  always_comb begin
    hst_rdata = '0;
    if (hit_mbox)
      hst_rdata = RD_W'(buf_flat[int'(hst_addr)*8 +: 8]);
    else if (hit_in)
      hst_rdata[BIT_POST] = ready_flag(busy, INVERT_READY);
    else if (hit_out)
      hst_rdata[BIT_AVAIL] = avail;
    else if (hit_ctl)
      hst_rdata[0] = ctl_q;
    else if (hst_addr == A_SLOT)
      hst_rdata = RD_W'(slot_q);
    else if (hst_addr == A_STATUS)
      hst_rdata = RD_W'(stat_q);
  end

  // R3: the doorbell flag tracks the in-flight command
  p_flag_tracks_r3: assert property (@(posedge clk) disable iff (!rst_n)
    hit_in |-> hst_rdata[BIT_POST] == (INVERT_READY ? !cmd_valid : cmd_valid));

  // R10: a doorbell write without the post bit starts nothing
  p_zero_post_r10: assert property (@(posedge clk) disable iff (!rst_n)
    hst_we && hit_in && !hst_wdata[BIT_POST] && !cmd_valid |=> !cmd_valid);
endmodule

// File: tb/cmd_doorbell_if_test.sv
`timescale 1ns/1ps
module cmd_doorbell_if_test;
  localparam int NB = 13;
  localparam int DW = NB * 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic        hst_we = 1'b0;
  logic [4:0]  hst_addr = '0;
  logic [7:0]  hst_wdata = '0;
  logic        cmd_ready = 1'b0;
  logic        comp_valid = 1'b0;
  logic [7:0]  comp_slot = '0;
  logic [15:0] comp_status = '0;

  logic [15:0]   rd_n, rd_i;
  logic          cv_n, cv_i, cr_n, cr_i, irq_n, irq_i;
  logic [DW-1:0] cd_n, cd_i;

  cmd_doorbell_if #(.INVERT_READY(1'b0)) uut (
    .clk(clk), .rst_n(rst_n), .hst_we(hst_we), .hst_addr(hst_addr),
    .hst_wdata(hst_wdata), .hst_rdata(rd_n), .cmd_valid(cv_n),
    .cmd_ready(cmd_ready), .cmd_data(cd_n), .comp_valid(comp_valid),
    .comp_ready(cr_n), .comp_slot(comp_slot), .comp_status(comp_status),
    .irq(irq_n));

  cmd_doorbell_if #(.INVERT_READY(1'b1)) uut_inv (
    .clk(clk), .rst_n(rst_n), .hst_we(hst_we), .hst_addr(hst_addr),
    .hst_wdata(hst_wdata), .hst_rdata(rd_i), .cmd_valid(cv_i),
    .cmd_ready(cmd_ready), .cmd_data(cd_i), .comp_valid(comp_valid),
    .comp_ready(cr_i), .comp_slot(comp_slot), .comp_status(comp_status),
    .irq(irq_i));

  // Behavioural reference model
  logic [7:0]  m_mbox [NB];
  logic [7:0]  m_shadow [NB];
  bit          m_full, m_avail, m_ack, m_en_n, m_dis_i;
  logic [7:0]  m_slot;
  logic [15:0] m_stat;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input logic [DW-1:0] act,
                     input logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [DW-1:0] exp_cmd();
    logic [DW-1:0] v = '0;
    for (int k = 0; k < NB; k++) v[k*8 +: 8] = m_shadow[k];
    return v;
  endfunction

  function automatic logic [15:0] exp_rd(input bit inv, input logic [4:0] a);
    if (int'(a) < NB) return {8'h00, m_mbox[a]};
    case (a)
      5'h10:   return {15'b0, inv ? !m_full : m_full};
      5'h11:   return {15'b0, m_avail};
      5'h12:   return {15'b0, inv ? m_dis_i : m_en_n};
      5'h13:   return {8'h00, m_slot};
      5'h14:   return m_stat;
      default: return 16'h0;
    endcase
  endfunction

  function automatic string addr_req(input logic [4:0] a);
    if (int'(a) < NB) return "R2";
    case (a)
      5'h10:   return "R3";
      5'h11:   return "R7";
      5'h12:   return "R9";
      default: return "R6";
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < NB; k++) begin m_mbox[k] = 8'h0; m_shadow[k] = 8'h0; end
      m_full = 0; m_avail = 0; m_ack = 0; m_en_n = 0; m_dis_i = 1;
      m_slot = 8'h0; m_stat = 16'h0;
    end else begin
      bit o_full, o_avail, o_ack;
      o_full = m_full; o_avail = m_avail; o_ack = m_ack;
      if (o_full && cmd_ready) m_full = 0;
      if (hst_we && hst_addr == 5'h10 && hst_wdata[0] && !o_full) begin
        for (int k = 0; k < NB; k++) m_shadow[k] = m_mbox[k];
        m_full = 1;
      end
      if (hst_we && int'(hst_addr) < NB) m_mbox[hst_addr] = hst_wdata;
      if (comp_valid && !o_avail && !o_ack) begin
        m_avail = 1; m_ack = 1; m_slot = comp_slot; m_stat = comp_status;
      end else begin
        if (hst_we && hst_addr == 5'h11 && hst_wdata[0]) m_avail = 0;
        if (hst_we && hst_addr == 5'h10 && hst_wdata[1] && !o_avail) m_ack = 0;
      end
      if (hst_we && hst_addr == 5'h12) begin
        m_en_n  = |hst_wdata;
        m_dis_i = hst_wdata[0];
      end
    end
  end

  // Every-cycle comparison of both variants against the model
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      chk(cv_n == m_full && cv_i == m_full, "R5 cmd_valid", {cv_n, cv_i}, {m_full, m_full});
      if (m_full)
        chk(cd_n == exp_cmd() && cd_i == exp_cmd(), "R4 cmd_data", cd_n, exp_cmd());
      chk(cr_n == !(m_avail || m_ack) && cr_i == !(m_avail || m_ack), "R8 comp_ready",
          {cr_n, cr_i}, {2{!(m_avail || m_ack)}});
      chk(irq_n == (m_avail && m_en_n), "R9 irq normal", irq_n, m_avail && m_en_n);
      chk(irq_i == (m_avail && !m_dis_i), "R9 irq inverted", irq_i, m_avail && !m_dis_i);
      chk(rd_n == exp_rd(0, hst_addr), addr_req(hst_addr), rd_n, exp_rd(0, hst_addr));
      chk(rd_i == exp_rd(1, hst_addr), addr_req(hst_addr), rd_i, exp_rd(1, hst_addr));
    end
  end

  task automatic wr(input logic [4:0] a, input logic [7:0] d);
    @(negedge clk); #2;
    hst_we = 1'b1; hst_addr = a; hst_wdata = d;
    @(negedge clk); #2;
    hst_we = 1'b0;
  endtask

  task automatic peek(input logic [4:0] a);
    @(negedge clk); #2;
    hst_addr = a;
    #5;
  endtask

  task automatic complete(input logic [7:0] s, input logic [15:0] st);
    @(negedge clk); #2;
    comp_valid = 1'b1; comp_slot = s; comp_status = st;
    @(negedge clk); #2;
    comp_valid = 1'b0;
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    #(20.0 * 200000);
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual=running expected=done");
      summary();
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] pat;
    hst_addr = 5'h10;
    repeat (3) @(posedge clk);
    #2;
    // R1 reset state
    chk(!cv_n && !cv_i, "R1 no command", {cv_n, cv_i}, 0);
    chk(!irq_n && !irq_i, "R1 irq low", {irq_n, irq_i}, 0);
    chk(rd_n[0] == 1'b0 && rd_i[0] == 1'b1, "R1 doorbell flag", {rd_n[0], rd_i[0]}, 2'b01);
    hst_addr = 5'h11; #1;
    chk(rd_n[0] == 1'b0, "R1 status-available", rd_n, 0);
    @(negedge clk); rst_n = 1'b1;

    for (int k = 0; k < NB; k++) wr(5'(k), 8'h30 + 8'(k));
    pat = '0;
    for (int k = 0; k < NB; k++) pat[k*8 +: 8] = 8'h30 + 8'(k);
    peek(5'h10);
    chk(rd_n[0] == 1'b0 && rd_i[0] == 1'b1, "R3 idle flag", {rd_n[0], rd_i[0]}, 2'b01);

    wr(5'h10, 8'h00);
    chk(!cv_n && !cv_i, "R10 zero write no post", {cv_n, cv_i}, 0);
    wr(5'h10, 8'h02);
    chk(!cv_n, "R10 sack-only write no post", cv_n, 0);

    wr(5'h10, 8'h01);
    chk(cv_n && cv_i, "R2 post offers command", {cv_n, cv_i}, 2'b11);
    chk(cd_n == pat, "R2 command bytes", cd_n, pat);
    peek(5'h10);
    chk(rd_n[0] == 1'b1 && rd_i[0] == 1'b0, "R3 busy flag", {rd_n[0], rd_i[0]}, 2'b10);

    wr(5'h00, 8'hEE);
    wr(5'h10, 8'h01);
    chk(cd_n == pat && cd_i == pat, "R4 in-flight data kept", cd_n, pat);
    peek(5'h00);
    chk(rd_n == 16'h00EE, "R4 mailbox byte updated", rd_n, 16'h00EE);

    repeat (3) @(negedge clk);
    chk(cv_n, "R5 held without ready", cv_n, 1);
    #2 cmd_ready = 1'b1;
    @(negedge clk); #2 cmd_ready = 1'b0;
    chk(!cv_n && !cv_i, "R5 dropped after take", {cv_n, cv_i}, 0);

    complete(8'hA5, 16'hBEEF);
    chk(!cr_n, "R8 ready low while available", cr_n, 0);
    peek(5'h11); chk(rd_n[0] == 1'b1, "R6 status-available set", rd_n, 1);
    peek(5'h13); chk(rd_n == 16'h00A5, "R6 slot", rd_n, 16'h00A5);
    peek(5'h14); chk(rd_n == 16'hBEEF, "R6 status word", rd_n, 16'hBEEF);
    chk(!irq_n && !irq_i, "R9 disabled after reset", {irq_n, irq_i}, 0);

    wr(5'h12, 8'h04);
    chk(irq_n && irq_i, "R9 enabled both", {irq_n, irq_i}, 2'b11);

    wr(5'h11, 8'h00);
    peek(5'h11); chk(rd_n[0] == 1'b1, "R7 zero write keeps flag", rd_n, 1);
    wr(5'h10, 8'h02);
    wr(5'h11, 8'h01);
    peek(5'h11); chk(rd_n[0] == 1'b0, "R7 cleared", rd_n, 0);
    chk(!irq_n, "R9 irq follows flag", irq_n, 0);
    chk(!cr_n, "R8 early sack ignored", cr_n, 0);
    wr(5'h10, 8'h02);
    chk(cr_n && cr_i, "R8 rearmed after sack", {cr_n, cr_i}, 2'b11);

    wr(5'h12, 8'h01);
    complete(8'h3C, 16'h1234);
    chk(irq_n && !irq_i, "R9 variants differ", {irq_n, irq_i}, 2'b10);
    wr(5'h11, 8'h01);
    wr(5'h10, 8'h02);

    for (int n = 0; n < 3000; n++) begin
      logic [31:0] r;
      @(negedge clk); #2;
      r = $urandom;
      cmd_ready   = r[0];
      comp_valid  = r[1];
      comp_slot   = 8'($urandom);
      comp_status = 16'($urandom);
      hst_we      = r[4:2] != 3'd0;
      hst_wdata   = r[15:8];
      case (r[18:16])
        3'd0, 3'd1: hst_addr = 5'(r[23:20] % NB);
        3'd2:       hst_addr = 5'h10;
        3'd3:       hst_addr = 5'h11;
        3'd4:       hst_addr = 5'h12;
        3'd5:       hst_addr = 5'h13;
        default:    hst_addr = 5'h14;
      endcase
    end
    @(negedge clk); #2;
    hst_we = 1'b0; cmd_ready = 1'b0; comp_valid = 1'b0;
    @(negedge clk); #2;
    finished = 1;
    summary();
    $finish;
  end
endmodule